// File: doc/BRIEF.md
# Two-Slot Statically Scheduled VLIW Core

This block is a compact in-order processor that fetches one 64-bit bundle every cycle and issues both of its 32-bit operations together. The low half of a bundle is the arithmetic/branch slot and the high half is the memory slot. Each slot has its own datapath: an adder for `addu`/`addi` plus a comparator and target adder for `bne` in the arithmetic slot, and a separate effective-address adder for `lw`/`sw` in the memory slot. A four-read, two-write register file lets both slots read two operands and write one result in the same cycle.

The hardware checks nothing. It has no interlocks, no forwarding network and no prediction. All ordering rules are fixed by the pipeline's timing, and the program's schedule must respect them. An arithmetic result can be used by the very next bundle. A loaded word can be used only from the second bundle after the load. A taken branch discards the one bundle fetched behind it.

Instruction and data memories are filled through dedicated load ports while reset is held. The data memory also has an asynchronous read-back port. A counter reports how many non-empty bundles have retired.

Top module: `vliw2_core`

## Requirements
- R1: A bundle is 64 bits: bits [31:0] are slot 0 and bits [63:32] are slot 1. The PC is a bundle index that starts at 0 after reset and advances by exactly one bundle per cycle unless a taken branch redirects it.
- R2: In slot 0, `addu` (opcode 0x00, funct 0x21) writes rs+rt into rd, and `addi` (opcode 0x08) writes rs plus the sign-extended 16-bit immediate into rt. The result is visible to the bundle that immediately follows.
- R3: In slot 1, `lw` (opcode 0x23) and `sw` (opcode 0x2B) use the address rs plus the sign-extended immediate, computed on an adder separate from slot 0. The data memory word index is the address divided by 4.
- R4: A value loaded by `lw` is not seen by the bundle right after the load; that bundle reads the register's old value. The loaded value is seen from the second following bundle onward.
- R5: Both operations of a bundle read register values from before that bundle. A `sw` whose bundle partner writes the stored register stores the old value.
- R6: `bne` (opcode 0x05) in slot 0 is taken when rs != rt. The target is the branch bundle's index + 1 + the sign-extended immediate, in bundle units. When the branch is taken, the single bundle fetched behind it has no effect, while slot 1 of the branch bundle still executes. When the branch is not taken, execution falls through.
- R7: An all-zero word, any unknown encoding, and any operation placed in the wrong slot (a load/store in slot 0, an ALU op or branch in slot 1) have no architectural effect.
- R8: If both slots of one bundle write the same register, the loaded value is what remains. Writes to register 0 are discarded, and register 0 always reads as 0.
- R9: `retired_cnt` is 0 after reset. It increases by one for each unsquashed bundle that holds at least one effective operation, when that bundle leaves the last stage, and it never changes by more than one per cycle.
- R10: Reset clears the PC, empties the pipeline and zeroes all registers. No store occurs while reset is held.
- R11: A scheduled loop of four bundles per iteration adds a scalar to every element of an array, walking the pointer down by 4 until it reaches zero. Each iteration retires 4 bundles for its 5 useful operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Instruction memory write enable |
| prog_addr | input | IA_W | Bundle index to write |
| prog_data | input | 64 | Bundle to write |
| dbg_we | input | 1 | Data memory side-port write enable |
| dbg_addr | input | DA_W | Data memory side-port word index |
| dbg_wdata | input | 32 | Data memory side-port write data |
| dbg_rdata | output | 32 | Data memory side-port read data (asynchronous) |
| retired_cnt | output | CNT_W | Count of retired non-empty bundles |

## Verification
The assertions assume that both memories are written only while reset is held. They also assume that the instruction memory depth is a power of two, so the bundle index wraps cleanly and the "one step per cycle" property stays valid. The stimulus loads every program and data word during reset, then releases reset and samples the results before the PC can wrap back to bundle 0. Every program obeys the schedule rules the hardware relies on, except where a test deliberately reads a register too early to show the stale value.

// File: rtl/vliw2_pkg.sv
package vliw2_pkg;

    localparam int XLEN     = 32;
    localparam int BUNDLE_W = 2 * XLEN;
    localparam int NREG     = 32;
    localparam int RIDX_W   = $clog2(NREG);
    localparam int NRD      = 4;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_BNE   = 6'h05;
    localparam logic [5:0] OPC_LW    = 6'h23;
    localparam logic [5:0] OPC_SW    = 6'h2B;
    localparam logic [5:0] FN_ADDU   = 6'h21;

    typedef enum logic [2:0] {
        K_NOP,
        K_ADDU,
        K_ADDI,
        K_BNE,
        K_LW,
        K_SW
    } op_kind_e;

    // one decoded operation
    typedef struct packed {
        op_kind_e          kind;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] dst;
        logic [XLEN-1:0]   imm;
    } uop_t;

    // execute -> memory stage payload
    typedef struct packed {
        logic              alu_we;
        logic [RIDX_W-1:0] alu_dst;
        logic [XLEN-1:0]   alu_val;
        logic              ld_en;
        logic [RIDX_W-1:0] ld_dst;
        logic              st_en;
        logic [XLEN-1:0]   st_data;
        logic [XLEN-1:0]   mem_addr;
        logic              useful;
    } xm_t;

    // memory -> load write-back payload
    typedef struct packed {
        logic              ld_en;
        logic [RIDX_W-1:0] ld_dst;
        logic              useful;
    } mw_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    // slot 0 accepts only addu / addi / bne
    function automatic uop_t decode_alu_slot(input logic [XLEN-1:0] w);
        uop_t u;
        u.kind = K_NOP;
        u.rs   = w[25:21];
        u.rt   = w[20:16];
        u.dst  = '0;
        u.imm  = sext16(w[15:0]);
        unique case (w[31:26])
            OPC_RTYPE: if (w[5:0] == FN_ADDU) begin
                u.kind = K_ADDU;
                u.dst  = w[15:11];
            end
            OPC_ADDI: begin
                u.kind = K_ADDI;
                u.dst  = w[20:16];
            end
            OPC_BNE: u.kind = K_BNE;
            default: u.kind = K_NOP;
        endcase
        return u;
    endfunction

    // slot 1 accepts only lw / sw
    function automatic uop_t decode_mem_slot(input logic [XLEN-1:0] w);
        uop_t u;
        u.kind = K_NOP;
        u.rs   = w[25:21];
        u.rt   = w[20:16];
        u.dst  = '0;
        u.imm  = sext16(w[15:0]);
        unique case (w[31:26])
            OPC_LW: begin
                u.kind = K_LW;
                u.dst  = w[20:16];
            end
            OPC_SW:  u.kind = K_SW;
            default: u.kind = K_NOP;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/vliw2_fetch.sv
module vliw2_fetch
    import vliw2_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    localparam int IA_W = $clog2(IMEM_DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_we,
    input  logic [IA_W-1:0]     load_addr,
    input  logic [BUNDLE_W-1:0] load_data,
    input  logic                redirect,
    input  logic [IA_W-1:0]     redirect_pc,
    output logic [IA_W-1:0]     pc_q,
    output logic                fx_valid,
    output logic [IA_W-1:0]     fx_pc,
    output logic [BUNDLE_W-1:0] fx_bundle
);

    logic [BUNDLE_W-1:0] imem [IMEM_DEPTH];

    always_ff @(posedge clk) begin
        if (load_we) begin
            imem[load_addr] <= load_data;
        end
    end

    // a taken branch squashes the bundle being fetched this cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q      <= '0;
            fx_valid  <= 1'b0;
            fx_pc     <= '0;
            fx_bundle <= '0;
        end else begin
            fx_pc     <= pc_q;
            fx_bundle <= imem[pc_q];
            fx_valid  <= !redirect;
            pc_q      <= redirect ? redirect_pc : pc_q + IA_W'(1);
        end
    end

endmodule

// File: rtl/vliw2_regfile.sv
module vliw2_regfile
    import vliw2_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NRD-1:0][RIDX_W-1:0]    raddr,
    output logic [NRD-1:0][XLEN-1:0]      rdata,
    input  logic                          we_a,
    input  logic [RIDX_W-1:0]             wa_a,
    input  logic [XLEN-1:0]               wd_a,
    input  logic                          we_b,
    input  logic [RIDX_W-1:0]             wa_b,
    input  logic [XLEN-1:0]               wd_b
);

    logic [XLEN-1:0] regs [NREG];
    logic            eff_a;
    logic            eff_b;

    assign eff_a = we_a && (wa_a != '0);
    assign eff_b = we_b && (wa_b != '0);

    // port b is written last, so it wins a same-cycle collision
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else begin
            if (eff_a) regs[wa_a] <= wd_a;
            if (eff_b) regs[wa_b] <= wd_b;
        end
    end

    // write-before-read: this cycle's writes are seen by this cycle's reads
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (raddr[p] == '0)                  rdata[p] = '0;
            else if (eff_b && wa_b == raddr[p])  rdata[p] = wd_b;
            else if (eff_a && wa_a == raddr[p])  rdata[p] = wd_a;
            else                                 rdata[p] = regs[raddr[p]];
        end
    end

endmodule

// File: rtl/vliw2_dmem.sv
module vliw2_dmem
    import vliw2_pkg::*;
#(
    parameter int DMEM_DEPTH = 64,
    localparam int DA_W = $clog2(DMEM_DEPTH)
) (
    input  logic            clk,
    input  logic            core_we,
    input  logic [DA_W-1:0] core_idx,
    input  logic [XLEN-1:0] core_wdata,
    output logic [XLEN-1:0] core_rdata,
    input  logic            side_we,
    input  logic [DA_W-1:0] side_idx,
    input  logic [XLEN-1:0] side_wdata,
    output logic [XLEN-1:0] side_rdata
);

    logic [XLEN-1:0] mem [DMEM_DEPTH];

    always_ff @(posedge clk) begin
        if (core_we) mem[core_idx] <= core_wdata;
        if (side_we) mem[side_idx] <= side_wdata;
        core_rdata <= mem[core_idx];
    end

    assign side_rdata = mem[side_idx];

endmodule

// File: rtl/vliw2_exec.sv
module vliw2_exec
    import vliw2_pkg::*;
#(
    parameter int IA_W = 6
) (
    input  logic                       valid,
    input  logic [BUNDLE_W-1:0]        bundle,
    input  logic [IA_W-1:0]            bpc,
    output logic [NRD-1:0][RIDX_W-1:0] raddr,
    input  logic [NRD-1:0][XLEN-1:0]   rdata,
    output xm_t                        xm_next,
    output logic                       redirect,
    output logic [IA_W-1:0]            target
);

    uop_t            u0;
    uop_t            u1;
    logic [XLEN-1:0] sum_rr;
    logic [XLEN-1:0] sum_ri;
    logic [XLEN-1:0] eff_addr;

    always_comb begin
        u0 = decode_alu_slot(valid ? bundle[XLEN-1:0]        : '0);
        u1 = decode_mem_slot(valid ? bundle[BUNDLE_W-1:XLEN] : '0);
    end

    // ports 0/1 feed slot 0, ports 2/3 feed slot 1
    assign raddr = {u1.rt, u1.rs, u0.rt, u0.rs};

    assign sum_rr   = rdata[0] + rdata[1];
    assign sum_ri   = rdata[0] + u0.imm;
    assign eff_addr = rdata[2] + u1.imm;   // dedicated address adder

    assign redirect = (u0.kind == K_BNE) && (rdata[0] != rdata[1]);
    assign target   = bpc + IA_W'(1) + u0.imm[IA_W-1:0];

    always_comb begin
        xm_next = '0;
        unique case (u0.kind)
            K_ADDU: begin
                xm_next.alu_we  = 1'b1;
                xm_next.alu_dst = u0.dst;
                xm_next.alu_val = sum_rr;
            end
            K_ADDI: begin
                xm_next.alu_we  = 1'b1;
                xm_next.alu_dst = u0.dst;
                xm_next.alu_val = sum_ri;
            end
            default: ;
        endcase
        unique case (u1.kind)
            K_LW: begin
                xm_next.ld_en  = 1'b1;
                xm_next.ld_dst = u1.dst;
            end
            K_SW: begin
                xm_next.st_en   = 1'b1;
                xm_next.st_data = rdata[3];
            end
            default: ;
        endcase
        xm_next.mem_addr = eff_addr;
        xm_next.useful   = (u0.kind != K_NOP) || (u1.kind != K_NOP);
    end

endmodule

// File: rtl/vliw2_core.sv
module vliw2_core
    import vliw2_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    parameter int DMEM_DEPTH = 64,
    parameter int CNT_W      = 32,
    localparam int IA_W = $clog2(IMEM_DEPTH),
    localparam int DA_W = $clog2(DMEM_DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                prog_we,
    input  logic [IA_W-1:0]     prog_addr,
    input  logic [BUNDLE_W-1:0] prog_data,
    input  logic                dbg_we,
    input  logic [DA_W-1:0]     dbg_addr,
    input  logic [XLEN-1:0]     dbg_wdata,
    output logic [XLEN-1:0]     dbg_rdata,
    output logic [CNT_W-1:0]    retired_cnt
);

    logic [IA_W-1:0]            pc_q;
    logic                       fx_valid;
    logic [IA_W-1:0]            fx_pc;
    logic [BUNDLE_W-1:0]        fx_bundle;
    logic                       redirect;
    logic [IA_W-1:0]            target;
    logic [NRD-1:0][RIDX_W-1:0] rf_raddr;
    logic [NRD-1:0][XLEN-1:0]   rf_rdata;
    xm_t                        xm_next;
    xm_t                        xm_q;
    mw_t                        mw_q;
    logic [XLEN-1:0]            ld_data;
    logic                       xm_st_en;
    logic                       unused_addr_bits;

    vliw2_fetch #(.IMEM_DEPTH(IMEM_DEPTH)) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .load_we     (prog_we),
        .load_addr   (prog_addr),
        .load_data   (prog_data),
        .redirect    (redirect),
        .redirect_pc (target),
        .pc_q        (pc_q),
        .fx_valid    (fx_valid),
        .fx_pc       (fx_pc),
        .fx_bundle   (fx_bundle)
    );

    vliw2_exec #(.IA_W(IA_W)) u_exec (
        .valid    (fx_valid),
        .bundle   (fx_bundle),
        .bpc      (fx_pc),
        .raddr    (rf_raddr),
        .rdata    (rf_rdata),
        .xm_next  (xm_next),
        .redirect (redirect),
        .target   (target)
    );

    // ALU result writes in the memory stage, load data one stage later
    vliw2_regfile u_rf (
        .clk   (clk),
        .rst   (rst),
        .raddr (rf_raddr),
        .rdata (rf_rdata),
        .we_a  (xm_q.alu_we),
        .wa_a  (xm_q.alu_dst),
        .wd_a  (xm_q.alu_val),
        .we_b  (mw_q.ld_en),
        .wa_b  (mw_q.ld_dst),
        .wd_b  (ld_data)
    );

    vliw2_dmem #(.DMEM_DEPTH(DMEM_DEPTH)) u_dmem (
        .clk        (clk),
        .core_we    (xm_q.st_en),
        .core_idx   (xm_q.mem_addr[DA_W+1:2]),
        .core_wdata (xm_q.st_data),
        .core_rdata (ld_data),
        .side_we    (dbg_we),
        .side_idx   (dbg_addr),
        .side_wdata (dbg_wdata),
        .side_rdata (dbg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            xm_q <= '0;
            mw_q <= '0;
        end else begin
            xm_q        <= xm_next;
            mw_q.ld_en  <= xm_q.ld_en;
            mw_q.ld_dst <= xm_q.ld_dst;
            mw_q.useful <= xm_q.useful;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            retired_cnt <= '0;
        end else if (mw_q.useful) begin
            retired_cnt <= retired_cnt + CNT_W'(1);
        end
    end

    assign xm_st_en         = xm_q.st_en;
    assign unused_addr_bits = ^{xm_q.mem_addr[XLEN-1:DA_W+2], xm_q.mem_addr[1:0]};

endmodule

// File: rtl/vliw2_checker.sv
module vliw2_checker
    import vliw2_pkg::*;
#(
    parameter int IA_W  = 6,
    parameter int CNT_W = 32
) (
    input logic                       clk,
    input logic                       rst,
    input logic [IA_W-1:0]            pc_q,
    input logic                       redirect,
    input logic                       fx_valid,
    input logic                       xm_st_en,
    input logic [CNT_W-1:0]           retired_cnt,
    input logic [NRD-1:0][RIDX_W-1:0] rf_raddr,
    input logic [NRD-1:0][XLEN-1:0]   rf_rdata
);

    localparam logic [IA_W-1:0]  PC_ONE  = IA_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    // R1: sequential fetch steps one bundle
    assert_pc_step_R1: assert property (@(posedge clk) disable iff (rst)
        !redirect |=> (pc_q == $past(pc_q) + PC_ONE));

    // R6: bundle behind a taken branch is squashed
    assert_squash_R6: assert property (@(posedge clk) disable iff (rst)
        redirect |=> !fx_valid);

    // R7: an empty or squashed fetch slot never produces a store
    assert_no_store_R7: assert property (@(posedge clk) disable iff (rst)
        !fx_valid |=> !xm_st_en);

    // R8: register 0 reads zero on every read port in use
    assert_zero_slot0_R8: assert property (@(posedge clk) disable iff (rst)
        (rf_raddr[0] == '0) |-> (rf_rdata[0] == '0));
    assert_zero_slot1_R8: assert property (@(posedge clk) disable iff (rst)
        (rf_raddr[2] == '0) |-> (rf_rdata[2] == '0));

    // R9: retirement counter moves by zero or one
    assert_retire_step_R9: assert property (@(posedge clk) disable iff (rst)
        (retired_cnt == $past(retired_cnt)) || (retired_cnt == $past(retired_cnt) + CNT_ONE));

endmodule

bind vliw2_core vliw2_checker #(.IA_W(IA_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pc_q        (pc_q),
    .redirect    (redirect),
    .fx_valid    (fx_valid),
    .xm_st_en    (xm_st_en),
    .retired_cnt (retired_cnt),
    .rf_raddr    (rf_raddr),
    .rf_rdata    (rf_rdata)
);

// File: tb/vliw2_core_test.sv
`timescale 1ns/1ps
module vliw2_core_test;

    localparam int CLK_NS = 4;
    localparam int IDEPTH = 64;
    localparam int DDEPTH = 64;
    localparam int RUN_CYC = 45;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_we = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [63:0] prog_data = '0;
    logic        dbg_we = 1'b0;
    logic [5:0]  dbg_addr = '0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;
    logic [31:0] retired_cnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    vliw2_core uut (
        .clk         (clk),
        .rst         (rst),
        .prog_we     (prog_we),
        .prog_addr   (prog_addr),
        .prog_data   (prog_data),
        .dbg_we      (dbg_we),
        .dbg_addr    (dbg_addr),
        .dbg_wdata   (dbg_wdata),
        .dbg_rdata   (dbg_rdata),
        .retired_cnt (retired_cnt)
    );

    localparam logic [31:0] NOP = 32'h0;

    function automatic logic [31:0] e_addu(input int rd, input int rs, input int rt);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h21};
    endfunction
    function automatic logic [31:0] e_imm(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] e_addi(input int rt, input int rs, input int imm);
        return e_imm(6'h08, rs, rt, imm);
    endfunction
    function automatic logic [31:0] e_bne(input int rs, input int rt, input int off);
        return e_imm(6'h05, rs, rt, off);
    endfunction
    function automatic logic [31:0] e_lw(input int rt, input int base, input int off);
        return e_imm(6'h23, base, rt, off);
    endfunction
    function automatic logic [31:0] e_sw(input int rt, input int base, input int off);
        return e_imm(6'h2B, base, rt, off);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // hold reset, clear both memories
    task automatic begin_program();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < IDEPTH; i++) begin
            prog_we = 1'b1; prog_addr = 6'(i); prog_data = '0;
            dbg_we  = 1'b1; dbg_addr  = 6'(i % DDEPTH); dbg_wdata = '0;
            @(negedge clk);
        end
        prog_we = 1'b0;
        dbg_we  = 1'b0;
    endtask

    task automatic put_bundle(input int idx, input logic [31:0] s0, input logic [31:0] s1);
        prog_we = 1'b1; prog_addr = 6'(idx); prog_data = {s1, s0};
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic put_word(input int idx, input logic [31:0] v);
        dbg_we = 1'b1; dbg_addr = 6'(idx); dbg_wdata = v;
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    task automatic run_program(input int ncyc);
        @(negedge clk);
        rst = 1'b0;
        repeat (ncyc) @(negedge clk);
    endtask

    task automatic get_word(input int idx, output logic [31:0] v);
        dbg_addr = 6'(idx);
        #1 v = dbg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] w;
        begin_program();
        put_word(0, 32'h0000_1234);
        @(negedge clk);
        check("R10 counter in reset", retired_cnt, 32'd0);
        run_program(2);
        check("R10 counter just after reset", retired_cnt, 32'd0);
        repeat (RUN_CYC) @(negedge clk);
        check("R7 all-nop program retires nothing", retired_cnt, 32'd0);
        get_word(0, w);
        check("R7 all-nop program leaves memory", w, 32'h0000_1234);
    endtask

    task automatic t_loop();
        logic [31:0] w;
        begin_program();
        put_bundle(0, e_addi(17, 0, 16), NOP);
        put_bundle(1, e_addi(18, 0, 7),  NOP);
        put_bundle(2, NOP,                e_lw(8, 17, 0));
        put_bundle(3, e_addi(17, 17, -4), NOP);
        put_bundle(4, e_addu(8, 8, 18),   NOP);
        put_bundle(5, e_bne(17, 0, -4),   e_sw(8, 17, 4));
        for (int i = 0; i < 8; i++) put_word(i, 32'(100 + i));
        run_program(RUN_CYC);
        for (int i = 1; i <= 4; i++) begin
            get_word(i, w);
            check($sformatf("R11 element %0d", i), w, 32'(100 + i + 7));
        end
        get_word(0, w);
        check("R3 word below array untouched", w, 32'd100);
        get_word(5, w);
        check("R3 word above array untouched", w, 32'd105);
        check("R9 R11 retired 2 setup + 4x4 loop bundles", retired_cnt, 32'd18);
    endtask

    task automatic t_load_use();
        logic [31:0] w;
        begin_program();
        put_word(0, 32'h0000_00A5);
        put_word(2, 32'hFFFF_FFFF);
        put_word(3, 32'hFFFF_FFFF);
        put_word(4, 32'hFFFF_FFFF);
        put_bundle(0, NOP,              e_lw(9, 0, 0));
        put_bundle(1, NOP,              e_sw(9, 0, 8));
        put_bundle(2, e_addu(10, 9, 9), e_sw(9, 0, 12));
        put_bundle(3, NOP,              e_sw(10, 0, 16));
        run_program(RUN_CYC);
        get_word(2, w);
        check("R4 next bundle sees pre-load value", w, 32'd0);
        get_word(3, w);
        check("R4 second bundle sees loaded value", w, 32'h0000_00A5);
        get_word(4, w);
        check("R2 ALU result seen by next bundle", w, 32'h0000_014A);
    endtask

    task automatic t_same_bundle();
        logic [31:0] w;
        begin_program();
        put_word(0, 32'h0000_0033);
        put_word(8, 32'h0000_DEAD);
        put_bundle(0, e_addi(11, 0, 5),   NOP);
        put_bundle(1, e_addi(11, 11, 1),  e_sw(11, 0, 20));
        put_bundle(2, NOP,                e_sw(11, 0, 24));
        put_bundle(3, e_addi(12, 0, 9),   e_lw(12, 0, 0));
        put_bundle(4, NOP,                NOP);
        put_bundle(5, NOP,                e_sw(12, 0, 28));
        put_bundle(6, e_addi(0, 0, 3),    e_lw(0, 0, 0));
        put_bundle(7, NOP,                NOP);
        put_bundle(8, NOP,                e_sw(0, 0, 32));
        run_program(RUN_CYC);
        get_word(5, w);
        check("R5 store reads value from before its bundle", w, 32'd5);
        get_word(6, w);
        check("R5 partner write visible to next bundle", w, 32'd6);
        get_word(7, w);
        check("R8 load wins same-bundle destination", w, 32'h0000_0033);
        get_word(8, w);
        check("R8 register 0 stays zero", w, 32'd0);
    endtask

    task automatic t_branch();
        logic [31:0] w;
        begin_program();
        for (int i = 9; i <= 12; i++) put_word(i, 32'h55);
        put_bundle(0, e_addi(14, 0, 1), NOP);
        put_bundle(1, e_bne(14, 0, 1),  e_sw(14, 0, 36));
        put_bundle(2, e_addi(15, 0, 2), e_sw(14, 0, 40));
        put_bundle(3, NOP,              e_sw(15, 0, 44));
        put_bundle(4, e_bne(0, 0, 5),   NOP);
        put_bundle(5, NOP,              e_sw(14, 0, 48));
        run_program(RUN_CYC);
        get_word(9, w);
        check("R6 branch bundle slot 1 executes", w, 32'd1);
        get_word(10, w);
        check("R6 squashed store has no effect", w, 32'h55);
        get_word(11, w);
        check("R6 squashed addi has no effect", w, 32'd0);
        get_word(12, w);
        check("R6 untaken branch falls through", w, 32'd1);
        check("R9 squashed bundle not counted", retired_cnt, 32'd5);
    endtask

    task automatic t_slot_type();
        logic [31:0] w;
        begin_program();
        put_word(0, 32'h99);
        for (int i = 13; i <= 15; i++) put_word(i, 32'h77);
        put_bundle(0, e_sw(0, 0, 52),   e_addi(16, 0, 9));
        put_bundle(1, e_lw(19, 0, 0),   e_addu(19, 0, 0));
        put_bundle(2, 32'hFC00_0000,    e_bne(0, 16, 3));
        put_bundle(3, NOP,              e_sw(16, 0, 56));
        put_bundle(4, NOP,              e_sw(19, 0, 60));
        run_program(RUN_CYC);
        get_word(13, w);
        check("R7 store in slot 0 ignored", w, 32'h77);
        get_word(14, w);
        check("R7 addi in slot 1 ignored", w, 32'd0);
        get_word(15, w);
        check("R7 load in slot 0 ignored", w, 32'd0);
        check("R9 only effective bundles retire", retired_cnt, 32'd2);
    endtask

    initial begin
        t_reset();
        t_loop();
        t_load_use();
        t_same_bundle();
        t_branch();
        t_slot_type();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule